// File: doc/BRIEF.md
# I2C Slave Byte Engine with Windowed Direction Control

This block is the byte-level engine of an I2C target. It watches the bus through two-flop synchronizers and finds START, repeated START and STOP. It shifts in the address byte and data bytes, acknowledges them, and shifts out data bytes when set to transmit. After each acknowledged byte it holds SCL low until software services the byte: a read strobe for received data, or a write of the next byte to send.

Software controls the transfer direction through a one-bit register. That bit does not always reach the engine at once. A write becomes effective immediately only inside an open window. The window opens at the rising SCL edge of an acknowledge clock, or at STOP, and closes at the next SCL rising edge. A write at any other time is parked as pending. It is applied at the next acknowledge-clock rising edge or STOP. A two-bit compatibility field set to 2'b11 removes this deferral. A pending status bit lets software see when a parked write has landed.

Top module: `i2cd_slave`

## Requirements
- R1: SCL and SDA pass through two synchronizing flops. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START puts the engine into address reception and releases any SCL hold.
- R2: The upper seven bits of the first byte after a START are compared with `own_addr_i`. On a match with effective direction 0, SDA is pulled low during the ninth clock. On a mismatch there is no acknowledge and no hold, and later bytes are ignored until the next START.
- R3: Received bits are sampled on SCL rising edges, MSB first. After the eighth bit, `rx_data_o` holds the whole byte, including the address byte. A data byte received with direction 0 is acknowledged.
- R4: After the falling edge of the ninth clock of an acknowledged byte, `scl_hold_o` is 1. It returns to 0 one cycle after an `rx_rd_i` or `tx_wr_i` strobe.
- R5: With effective direction 1 in the data phase, the engine sends `tx_data_i` MSB first. The MSB is presented from the `tx_wr_i` strobe, and each following bit after an SCL falling edge. SDA is released for the ninth clock. If the master pulls SDA low at the ninth clock, SCL is held. If it does not (NACK), there is no hold and the engine idles until START.
- R6: After reset, and from a ninth-clock SCL rising edge or a STOP until the next SCL rising edge, a `dir_wr_i` strobe sets `dir_eff_o` one cycle later and leaves `dir_pending_o` at 0.
- R7: A `dir_wr_i` strobe outside that window leaves `dir_eff_o` unchanged and sets `dir_pending_o` to 1. The stored value becomes effective, and pending clears, at the next ninth-clock SCL rising edge or STOP.
- R8: If a pending write of 0 is still parked when a repeated START is followed by a matching address, the address is not acknowledged, because the effective direction is still 1. The effective direction becomes 0 at that byte's ninth-clock rising edge.
- R9: With `compat_mode_i` equal to 2'b11, every `dir_wr_i` strobe takes effect one cycle later and pending stays 0.
- R10: Reset leaves `dir_eff_o` = 0, `dir_pending_o` = 0, `scl_hold_o` = 0 and `sda_low_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_hold_o | output | 1 | 1 pulls SCL low (wait for software) |
| sda_low_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Seven-bit slave address |
| compat_mode_i | input | 2 | 2'b11 disables direction deferral |
| dir_wr_i | input | 1 | Direction register write strobe |
| dir_wdata_i | input | 1 | Direction written (1 = transmit) |
| tx_wr_i | input | 1 | Data register write strobe, releases hold |
| tx_data_i | input | 8 | Byte to transmit |
| rx_rd_i | input | 1 | Data register read strobe, releases hold |
| rx_data_o | output | 8 | Last received byte |
| dir_eff_o | output | 1 | Direction the engine currently uses |
| dir_pending_o | output | 1 | A direction write is parked |
| addressed_o | output | 1 | Engine is in the data phase of a matched transfer |

## Verification
The bench targets the direction window:
- It makes writes just after an ordinary SCL rise, between the rise and a repeated START, and after STOP. An engine that ignored the window would apply the repeated-START clear at once and acknowledge the address. One that lost the parked value would never return to receive.
- It checks the compatibility setting on the same repeated-START sequence. An engine that ignored it would still leave the address unacknowledged.
- It checks that a mismatched address, and the bytes that follow it, get no acknowledge and no hold.
- It checks that a master NACK on a sent byte leaves SCL free. An engine that held SCL anyway would stall the bus.

// File: rtl/i2cd_pkg.sv
package i2cd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_e;

    localparam logic [1:0] CMODE_NODEFER = 2'b11;

endpackage

// File: rtl/i2cd_sync.sv
module i2cd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sh = {sync_q.scl_sh[STAGES-2:0], scl_i};
        sync_d.sda_sh = {sync_q.sda_sh[STAGES-2:0], sda_i};
        sync_d.scl_p  = sync_q.scl_sh[STAGES-1];
        sync_d.sda_p  = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_s     = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~sync_q.scl_p;
    assign scl_fall  = ~scl_s & sync_q.scl_p;
    assign start_det = sync_q.sda_p & ~sda_s & scl_s & sync_q.scl_p;
    assign stop_det  = ~sync_q.sda_p & sda_s & scl_s & sync_q.scl_p;

    // warm-up counter used only by the latency checks below
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R1
            scl_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3) |-> (scl_s == $past(scl_i, 2)));
            // R1
            sda_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == 2'd3) |-> (sda_s == $past(sda_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/i2cd_dirctl.sv
module i2cd_dirctl
    import i2cd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       wdata_i,
    input  logic [1:0] cmode_i,
    input  logic       ninth_rise_i,
    input  logic       scl_rise_i,
    input  logic       stop_i,
    output logic       eff_o,
    output logic       pend_o
);

    typedef struct packed {
        logic eff;
        logic sw;
        logic pend;
        logic win;
    } dir_t;

    dir_t dir_q, dir_d;
    logic apply_evt;
    logic win_now;

    always_comb begin
        dir_d     = dir_q;
        apply_evt = ninth_rise_i | stop_i;
        win_now   = apply_evt | (dir_q.win & ~scl_rise_i);
        dir_d.win = win_now;
        if (apply_evt && dir_q.pend) begin
            dir_d.eff  = dir_q.sw;
            dir_d.pend = 1'b0;
        end
        if (wr_i) begin
            dir_d.sw = wdata_i;
            if (win_now || cmode_i == CMODE_NODEFER) begin
                dir_d.eff  = wdata_i;
                dir_d.pend = 1'b0;
            end else begin
                dir_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '{eff: 1'b0, sw: 1'b0, pend: 1'b0, win: 1'b1};
        else        dir_q <= dir_d;
    end

    assign eff_o  = dir_q.eff;
    assign pend_o = dir_q.pend;

    // R7
    dir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !ninth_rise_i && !stop_i) |=> ($stable(eff_o) && $stable(pend_o)));
    // R7
    dir_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && stop_i && !wr_i) |=> !pend_o);
    // R9
    nodefer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && cmode_i == CMODE_NODEFER) |=> (!pend_o && eff_o == $past(wdata_i)));
    // R6
    win_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && stop_i) |=> (!pend_o && eff_o == $past(wdata_i)));

endmodule

// File: rtl/i2cd_slave.sv
module i2cd_slave
    import i2cd_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_hold_o,
    output logic              sda_low_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [1:0]        compat_mode_i,
    input  logic              dir_wr_i,
    input  logic              dir_wdata_i,
    input  logic              tx_wr_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              rx_rd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              dir_eff_o,
    output logic              dir_pending_o,
    output logic              addressed_o
);

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(DATA_W + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-2:0] rx_sh;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_data;
        logic              ack_drv;
        logic              hold;
    } eng_t;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic ninth_rise;
    logic dir_eff, dir_pend;
    logic addr_match;
    logic txing;

    i2cd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eng_t eng_q, eng_d;

    assign ninth_rise = scl_rise && (eng_q.phase != PH_IDLE) && (eng_q.bitcnt == LAST_BIT);

    i2cd_dirctl u_dir (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (dir_wr_i),
        .wdata_i      (dir_wdata_i),
        .cmode_i      (compat_mode_i),
        .ninth_rise_i (ninth_rise),
        .scl_rise_i   (scl_rise),
        .stop_i       (stop_det),
        .eff_o        (dir_eff),
        .pend_o       (dir_pend)
    );

    assign addr_match = (eng_q.rx_data[DATA_W-1 -: ADDR_W] == own_addr_i);
    assign txing      = (eng_q.phase == PH_DATA) && dir_eff;

    always_comb begin
        eng_d = eng_q;
        if (start_det) begin
            eng_d.phase   = PH_ADDR;
            eng_d.bitcnt  = '0;
            eng_d.ack_drv = 1'b0;
            eng_d.hold    = 1'b0;
        end else if (stop_det) begin
            eng_d.phase   = PH_IDLE;
            eng_d.bitcnt  = '0;
            eng_d.ack_drv = 1'b0;
            eng_d.hold    = 1'b0;
        end else if (eng_q.phase != PH_IDLE) begin
            if (scl_rise) begin
                if (eng_q.bitcnt < LAST_BIT) begin
                    eng_d.rx_sh = {eng_q.rx_sh[DATA_W-3:0], sda_s};
                    if (eng_q.bitcnt == PRE_LAST)
                        eng_d.rx_data = {eng_q.rx_sh, sda_s};
                end
                if (eng_q.bitcnt == LAST_BIT && txing && sda_s)
                    eng_d.phase = PH_SKIP;
                if (eng_q.bitcnt <= LAST_BIT)
                    eng_d.bitcnt = eng_q.bitcnt + 1'b1;
            end
            if (scl_fall) begin
                if (eng_q.bitcnt == LAST_BIT) begin
                    if (eng_q.phase == PH_ADDR) begin
                        if (addr_match && !dir_eff) begin
                            eng_d.ack_drv = 1'b1;
                            eng_d.phase   = PH_DATA;
                        end else begin
                            eng_d.phase = PH_SKIP;
                        end
                    end else if (eng_q.phase == PH_DATA && !dir_eff) begin
                        eng_d.ack_drv = 1'b1;
                    end
                end else if (eng_q.bitcnt == ACK_BIT) begin
                    eng_d.ack_drv = 1'b0;
                    eng_d.bitcnt  = '0;
                    if (eng_q.phase == PH_DATA)
                        eng_d.hold = 1'b1;
                end else if (eng_q.bitcnt != '0 && txing) begin
                    eng_d.tx_sh = {eng_q.tx_sh[DATA_W-2:0], 1'b1};
                end
            end
        end
        if (rx_rd_i || tx_wr_i)
            eng_d.hold = 1'b0;
        if (tx_wr_i)
            eng_d.tx_sh = tx_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q         <= '0;
            eng_q.phase   <= PH_IDLE;
            eng_q.tx_sh   <= '1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign scl_hold_o    = eng_q.hold;
    assign sda_low_o     = eng_q.ack_drv |
                           (txing && (eng_q.bitcnt < LAST_BIT) && !eng_q.tx_sh[DATA_W-1]);
    assign rx_data_o     = eng_q.rx_data;
    assign dir_eff_o     = dir_eff;
    assign dir_pending_o = dir_pend;
    assign addressed_o   = (eng_q.phase == PH_DATA);

    // R1
    start_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (eng_q.phase == PH_ADDR && !scl_hold_o));
    // R2
    addr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_q.ack_drv) && $past(eng_q.phase) == PH_ADDR)
            |-> ($past(eng_q.rx_data[DATA_W-1 -: ADDR_W]) == $past(own_addr_i)));
    // R8
    ack_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.ack_drv) |-> !$past(dir_eff));
    // R4
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold_o && (rx_rd_i || tx_wr_i) && !scl_fall) |=> !scl_hold_o);
    // R5
    nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ninth_rise && txing && sda_s && !start_det && !stop_det) |=> (eng_q.phase == PH_SKIP));
    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.phase == PH_SKIP) |-> (!sda_low_o && !scl_hold_o));

endmodule

// File: tb/sim_i2cd_slave.sv
module sim_i2cd_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_hold, sda_low;
    logic scl_w, sda_w;
    logic [1:0] cmode = 2'b00;
    logic dir_wr = 1'b0, dir_wdata = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic dir_eff, dir_pend, addressed;

    assign scl_w = scl_m & ~scl_hold;
    assign sda_w = sda_m & ~sda_low;

    i2cd_slave u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_w),
        .sda_i         (sda_w),
        .scl_hold_o    (scl_hold),
        .sda_low_o     (sda_low),
        .own_addr_i    (OWN),
        .compat_mode_i (cmode),
        .dir_wr_i      (dir_wr),
        .dir_wdata_i   (dir_wdata),
        .tx_wr_i       (tx_wr),
        .tx_data_i     (tx_data),
        .rx_rd_i       (rx_rd),
        .rx_data_o     (rx_data),
        .dir_eff_o     (dir_eff),
        .dir_pending_o (dir_pend),
        .addressed_o   (addressed)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    // behavioural reference state
    bit m_eff = 0, m_pend = 0, m_win = 1, m_sw = 0, m_hold = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always begin
        @(posedge clk);
        #2;
        if (cmp_en && !done) begin
            check("R6/R7 dir_eff per cycle", dir_eff, m_eff);
            check("R7 dir_pending per cycle", dir_pend, m_pend);
            check("R4 scl_hold per cycle", scl_hold, m_hold);
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_apply();
        m_win = 1;
        if (m_pend) begin m_eff = m_sw; m_pend = 0; end
    endtask

    task automatic scl_up(input bit ninth);
        int k = 0;
        cmp_en = 0;
        scl_m = 1'b1;
        while (scl_w !== 1'b1 && k < 60) begin @(negedge clk); k++; end
        if (scl_w !== 1'b1) check("R4 SCL released", 0, 1);
        wclk(Q);
        if (ninth) m_apply(); else m_win = 0;
        cmp_en = 1;
    endtask

    task automatic scl_dn(input bit ninth, input bit hv);
        cmp_en = 0;
        scl_m = 1'b0;
        wclk(Q);
        if (ninth) m_hold = hv;
        cmp_en = 1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            wclk(Q);
            scl_up(0);
            scl_dn(0, 0);
        end
        sda_m = 1'b1;
        wclk(Q);
        scl_up(1);
        check(tag, {31'd0, ~sda_w}, {31'd0, exp_ack});
        scl_dn(1, exp_ack);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1;
            wclk(Q);
            scl_up(0);
            got[i] = sda_w;
            scl_dn(0, 0);
        end
        sda_m = ~mack;
        wclk(Q);
        scl_up(1);
        scl_dn(1, mack);
        sda_m = 1'b1;
        wclk(Q);
    endtask

    task automatic restart_a();
        sda_m = 1'b1;
        wclk(Q);
        if (scl_m == 1'b0) scl_up(0);
    endtask

    task automatic start_b();
        cmp_en = 0;
        sda_m = 1'b0;
        wclk(Q);
        m_hold = 0;
        cmp_en = 1;
        scl_dn(0, 0);
    endtask

    task automatic stop_a();
        sda_m = 1'b0;
        wclk(Q);
        scl_up(0);
    endtask

    task automatic stop_b();
        cmp_en = 0;
        sda_m = 1'b1;
        wclk(Q);
        m_apply();
        m_hold = 0;
        cmp_en = 1;
    endtask

    task automatic sw_dir(input bit v);
        cmp_en = 0;
        dir_wr = 1'b1; dir_wdata = v;
        @(negedge clk);
        dir_wr = 1'b0;
        m_sw = v;
        if (m_win || cmode == 2'b11) begin m_eff = v; m_pend = 0; end
        else m_pend = 1;
        wclk(1);
        cmp_en = 1;
    endtask

    task automatic sw_rd();
        cmp_en = 0;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        m_hold = 0;
        wclk(1);
        cmp_en = 1;
    endtask

    task automatic sw_tx(input logic [7:0] b);
        cmp_en = 0;
        tx_wr = 1'b1; tx_data = b;
        @(negedge clk);
        tx_wr = 1'b0;
        m_hold = 0;
        wclk(1);
        cmp_en = 1;
    endtask

    initial begin
        logic [7:0] got;
        wclk(5);
        check("R10 reset dir_eff", dir_eff, 0);
        check("R10 reset pending", dir_pend, 0);
        check("R10 reset scl_hold", scl_hold, 0);
        check("R10 reset sda_low", sda_low, 0);
        rst_n = 1'b1;
        wclk(3);
        cmp_en = 1;

        // R10 / R6: window open after reset
        sw_dir(1);
        check("R6 immediate after reset", dir_eff, 1);
        check("R6 no pending after reset", dir_pend, 0);
        sw_dir(0);

        // address + data receive
        restart_a(); start_b();
        send_byte({OWN, 1'b0}, 1, "R2 address ack");
        check("R3 rx address byte", rx_data, {OWN, 1'b0});
        check("R4 hold after address", scl_hold, 1);
        check("R2 addressed", addressed, 1);
        sw_rd();
        check("R4 release on read", scl_hold, 0);
        send_byte(8'h3C, 1, "R3 data ack");
        check("R3 rx data byte", rx_data, 8'h3C);

        // switch to transmit in window, send a byte
        sw_dir(1);
        check("R6 immediate in window", dir_eff, 1);
        check("R6 pending clear in window", dir_pend, 0);
        sw_tx(8'hA5);
        read_byte(1, got);
        check("R5 transmitted byte", got, 8'hA5);
        check("R5 hold after master ack", scl_hold, 1);

        // R8: clear parked across repeated START
        sw_tx(8'hC3);
        restart_a();
        sw_dir(0);
        check("R7 pending set outside window", dir_pend, 1);
        check("R7 eff unchanged while pending", dir_eff, 1);
        start_b();
        send_byte({OWN, 1'b0}, 0, "R8 no ack while transmit effective");
        check("R8 eff applied at ninth rise", dir_eff, 0);
        check("R8 pending cleared", dir_pend, 0);
        check("R8 no hold", scl_hold, 0);
        stop_a(); stop_b();

        // R9: compatibility setting removes deferral
        cmode = 2'b11;
        restart_a(); start_b();
        send_byte({OWN, 1'b0}, 1, "R9 setup address ack");
        sw_dir(1);
        sw_tx(8'hC3);
        restart_a();
        sw_dir(0);
        check("R9 no pending", dir_pend, 0);
        check("R9 immediate eff", dir_eff, 0);
        start_b();
        send_byte({OWN, 1'b0}, 1, "R9 address ack after restart");
        check("R9 hold", scl_hold, 1);
        sw_rd();
        stop_a(); stop_b();
        cmode = 2'b00;

        // R2 mismatch, R7 applied at STOP
        restart_a(); start_b();
        send_byte(8'h66, 0, "R2 mismatch no ack");
        check("R2 mismatch no hold", scl_hold, 0);
        send_byte({OWN, 1'b0}, 0, "R2 ignored until START");
        stop_a();
        sw_dir(1);
        check("R7 pending before STOP", dir_pend, 1);
        check("R7 eff held before STOP", dir_eff, 0);
        stop_b();
        check("R7 eff applied at STOP", dir_eff, 1);
        check("R7 pending cleared at STOP", dir_pend, 0);
        sw_dir(0);
        check("R6 immediate after STOP", dir_eff, 0);

        // R5 master NACK
        restart_a(); start_b();
        send_byte({OWN, 1'b0}, 1, "R2 address ack 2");
        sw_dir(1);
        sw_tx(8'h5B);
        read_byte(0, got);
        check("R5 transmitted byte 2", got, 8'h5B);
        check("R5 no hold after NACK", scl_hold, 0);
        check("R5 SDA released after NACK", sda_low, 0);
        stop_a(); stop_b();
        sw_dir(0);
        check("R1 idle after STOP", addressed, 0);

        wclk(4);
        done = 1'b1;
        cmp_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule